// File: doc/BRIEF.md
# Paged register window behind a management PHY address

This block sits on the register side of a management (MDIO-style) port. It answers 16-bit register reads and writes aimed at one fixed PHY address and turns them into accesses to a wide internal register file. That register file is organised as 8-bit pages of 8-bit offsets, and each register holds up to 64 bits. The serial framing of the management bus is handled elsewhere. This block only sees a decoded register port: PHY address, register address, write data, and write and read strobes. It returns registered read data.

Software first selects a page, with the accept bit set. For a write, it then loads up to four 16-bit staging words. It then writes a command word that carries the register offset and a read or write request bit. Those request bits act as busy flags. They read back as 1 while the internal access runs, and they drop when the register file signals completion. A read result is deposited into the staging words before the busy flag clears, so software can poll the command word and then collect the 64-bit value.

The internal side is a request/done master. The request stays high for the whole access, and page, offset, direction and write value stay frozen until a done pulse arrives. The latency is variable.

Top module: `pseudo_phy_window`

## Requirements
- R1: After reset the page, command offset, busy flags and all four staging words are 0, `mgmt_rdata` is 0 and `rb_req` is low.
- R2: A write to register 0x10 with bit 0 set loads bits 15:8 as the current page. Reading 0x10 returns the page in bits 15:8 and 0 in bits 7:0.
- R3: A write to register 0x10 with bit 0 clear leaves the current page unchanged.
- R4: A write to register 0x11 while idle records bits 15:8 as the offset. If bit 0 or bit 1 is set, `rb_req` is high from the next cycle on, with `rb_page`, `rb_offset` and `rb_wr` presented. `rb_req` stays high and these outputs stay stable until the cycle in which `rb_done` is sampled high. A command with neither bit set starts nothing.
- R5: Reading 0x11 returns the offset in bits 15:8, the read busy flag in bit 1, the write busy flag in bit 0, and 0 elsewhere. A busy flag is 1 from the command until the `rb_done` edge and 0 afterwards.
- R6: A command with both bit 0 and bit 1 set performs a read: `rb_wr` is low and only bit 1 reads back as busy.
- R7: A write to 0x11 while an access is in progress is ignored, including its offset.
- R8: For an internal write, `rb_wdata` equals the staging words as loaded before the command: 0x18 in bits 15:0, 0x19 in 31:16, 0x1A in 47:32, 0x1B in 63:48.
- R9: For an internal read, the staging words take `rb_rdata` (same bit mapping) on the edge where `rb_done` is sampled, which is the same edge on which the busy flag clears.
- R10: Writes to 0x18–0x1B while idle set the addressed staging word, and reads of these registers return it.
- R11: Reads of any other register address, or of any address at a PHY address other than `PHY_ADDR`, return 0. Writes at another PHY address have no effect.
- R12: Writes to 0x10 or 0x18–0x1B while an access is in progress are ignored.
- R13: `mgmt_rdata` is updated on the clock edge that samples `mgmt_re` and holds its value when no read strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mgmt_phy | input | 5 | PHY address of the management access |
| mgmt_addr | input | 5 | Register address of the management access |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_we | input | 1 | Management write strobe, one cycle per write |
| mgmt_re | input | 1 | Management read strobe, one cycle per read |
| mgmt_rdata | output | 16 | Registered read data, valid the cycle after `mgmt_re` |
| rb_req | output | 1 | Internal access in progress |
| rb_wr | output | 1 | 1 for an internal write, 0 for a read |
| rb_page | output | 8 | Page of the internal access |
| rb_offset | output | 8 | Offset of the internal access |
| rb_wdata | output | 64 | Value for an internal write |
| rb_rdata | input | 64 | Value returned by the register file, sampled with `rb_done` |
| rb_done | input | 1 | One-cycle completion pulse from the register file |

## Verification
The bench builds the block with its defaults: four staging words, which gives a 64-bit internal value, and the window at PHY address 30. With four words, every staging slot and the full scatter/gather of a 64-bit value can be checked end to end. Foreign PHY addresses such as 5 are also in reach. The register file model's latency can be set at run time, from zero cycles up to twenty. This lets the bench reach both commands that finish before the next poll and long accesses, during which the bench issues page, staging and command writes while busy and reads the busy flags back.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
  localparam int unsigned MG_AW = 5;
  localparam int unsigned MG_DW = 16;
  localparam int unsigned PG_W  = 8;
  localparam int unsigned OF_W  = 8;

  localparam logic [MG_AW-1:0] ADDR_PAGE = 5'h10;
  localparam logic [MG_AW-1:0] ADDR_CMD  = 5'h11;
  localparam logic [MG_AW-1:0] ADDR_STG0 = 5'h18;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_state_e;
endpackage

// File: rtl/ppw_rst_sync.sv
module ppw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ppw_page_reg.sv
module ppw_page_reg
  import ppw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_we,
  input  logic [MG_DW-1:0] wdata,
  output logic [PG_W-1:0]  page
);
  logic [PG_W-1:0] page_q;
  logic [PG_W-1:0] page_d;
  logic            page_en;

  always_comb begin
    page_en = page_we && wdata[0];
    page_d  = wdata[MG_DW-1 -: PG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_en) page_q <= page_d;
  end

  assign page = page_q;

  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (page_we && !wdata[0]) |=> $stable(page_q)); // R3
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (page_we && wdata[0]) |=> (page_q == $past(wdata[MG_DW-1 -: PG_W]))); // R2
endmodule

// File: rtl/ppw_cmd_ctrl.sv
module ppw_cmd_ctrl
  import ppw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [MG_DW-1:0] wdata,
  input  logic             rb_done,
  output logic             busy,
  output logic             is_read,
  output logic [OF_W-1:0]  offset,
  output logic [MG_DW-1:0] status
);
  acc_state_e      state_q, state_d;
  logic [OF_W-1:0] ofs_q, ofs_d;
  logic            ofs_en;
  logic            rd_busy, wr_busy;

  always_comb begin
    state_d = state_q;
    ofs_d   = wdata[MG_DW-1 -: OF_W];
    ofs_en  = 1'b0;
    unique case (state_q)
      ACC_IDLE: begin
        if (cmd_we) begin
          ofs_en = 1'b1;
          if (wdata[1])      state_d = ACC_READ;
          else if (wdata[0]) state_d = ACC_WRITE;
        end
      end
      ACC_WRITE, ACC_READ: begin
        if (rb_done) state_d = ACC_IDLE;
      end
      default: state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACC_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ofs_q <= '0;
    else if (ofs_en) ofs_q <= ofs_d;
  end

  always_comb begin
    rd_busy = (state_q == ACC_READ);
    wr_busy = (state_q == ACC_WRITE);
    busy    = rd_busy || wr_busy;
    is_read = rd_busy;
    offset  = ofs_q;
    status  = {ofs_q, {(MG_DW-OF_W-2){1'b0}}, rd_busy, wr_busy};
  end

  AST_BUSY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_busy, wr_busy})); // R6
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> $stable(ofs_q)); // R7
  AST_BOTH_BITS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && wdata[1]) |=> rd_busy); // R6
endmodule

// File: rtl/ppw_stage.sv
module ppw_stage
  import ppw_pkg::*;
#(
  parameter int unsigned NWORDS = 4,
  localparam int unsigned IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int unsigned VAL_W = NWORDS * MG_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_we,
  input  logic [IDX_W-1:0] idx,
  input  logic [MG_DW-1:0] wdata,
  input  logic             load_en,
  input  logic [VAL_W-1:0] load_val,
  output logic [VAL_W-1:0] value,
  output logic [MG_DW-1:0] rd_word
);
  logic [MG_DW-1:0] word_q [NWORDS];

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    logic [MG_DW-1:0] word_d;
    logic             word_en;

    always_comb begin
      word_en = load_en || (word_we && (idx == IDX_W'(gi)));
      word_d  = load_en ? load_val[gi*MG_DW +: MG_DW] : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q[gi] <= '0;
      else if (word_en) word_q[gi] <= word_d;
    end

    assign value[gi*MG_DW +: MG_DW] = word_q[gi];
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (idx == IDX_W'(k)) rd_word = word_q[k];
    end
  end

  AST_NO_LOAD_AND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && word_we)); // R12
endmodule

// File: rtl/pseudo_phy_window.sv
module pseudo_phy_window
  import ppw_pkg::*;
#(
  parameter int unsigned NWORDS   = 4,
  parameter logic [4:0]  PHY_ADDR = 5'd30,
  localparam int unsigned IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int unsigned VAL_W = NWORDS * MG_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       mgmt_phy,
  input  logic [4:0]       mgmt_addr,
  input  logic [15:0]      mgmt_wdata,
  input  logic             mgmt_we,
  input  logic             mgmt_re,
  output logic [15:0]      mgmt_rdata,
  output logic             rb_req,
  output logic             rb_wr,
  output logic [7:0]       rb_page,
  output logic [7:0]       rb_offset,
  output logic [VAL_W-1:0] rb_wdata,
  input  logic [VAL_W-1:0] rb_rdata,
  input  logic             rb_done
);
  logic             rst_ns;
  logic             phy_hit, wr_hit;
  logic             page_sel, cmd_sel, stg_sel;
  logic             page_we, cmd_we, stg_we, stg_load;
  logic             busy, is_read;
  logic [IDX_W-1:0] stg_idx;
  logic [VAL_W-1:0] stg_val;
  logic [MG_DW-1:0] stg_word, cmd_status;
  logic [PG_W-1:0]  page;
  logic [OF_W-1:0]  offset;
  logic [MG_DW-1:0] rd_mux;
  logic [MG_DW-1:0] rdata_q, rdata_d;
  logic             rdata_en;

  ppw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  always_comb begin
    phy_hit  = (mgmt_phy == PHY_ADDR);
    wr_hit   = mgmt_we && phy_hit;
    page_sel = (mgmt_addr == ADDR_PAGE);
    cmd_sel  = (mgmt_addr == ADDR_CMD);
    stg_sel  = (int'(mgmt_addr) >= int'(ADDR_STG0)) &&
               (int'(mgmt_addr) <  int'(ADDR_STG0) + int'(NWORDS));
    stg_idx  = IDX_W'(mgmt_addr - ADDR_STG0);
    page_we  = wr_hit && page_sel && !busy;
    cmd_we   = wr_hit && cmd_sel;
    stg_we   = wr_hit && stg_sel && !busy;
    stg_load = busy && is_read && rb_done;
  end

  ppw_page_reg u_page (
    .clk     (clk),
    .rst_n   (rst_ns),
    .page_we (page_we),
    .wdata   (mgmt_wdata),
    .page    (page)
  );

  ppw_cmd_ctrl u_cmd (
    .clk     (clk),
    .rst_n   (rst_ns),
    .cmd_we  (cmd_we),
    .wdata   (mgmt_wdata),
    .rb_done (rb_done),
    .busy    (busy),
    .is_read (is_read),
    .offset  (offset),
    .status  (cmd_status)
  );

  ppw_stage #(.NWORDS(NWORDS)) u_stage (
    .clk      (clk),
    .rst_n    (rst_ns),
    .word_we  (stg_we),
    .idx      (stg_idx),
    .wdata    (mgmt_wdata),
    .load_en  (stg_load),
    .load_val (rb_rdata),
    .value    (stg_val),
    .rd_word  (stg_word)
  );

  always_comb begin
    rd_mux = '0;
    if (phy_hit) begin
      if (page_sel)     rd_mux = {page, {(MG_DW-PG_W){1'b0}}};
      else if (cmd_sel) rd_mux = cmd_status;
      else if (stg_sel) rd_mux = stg_word;
    end
    rdata_en = mgmt_re;
    rdata_d  = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign mgmt_rdata = rdata_q;
  assign rb_req     = busy;
  assign rb_wr      = busy && !is_read;
  assign rb_page    = page;
  assign rb_offset  = offset;
  assign rb_wdata   = stg_val;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (rb_req && !rb_done) |=> rb_req); // R4
  AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_ns)
    (rb_req && !rb_done) |=> ($stable(rb_page) && $stable(rb_offset) &&
                              $stable(rb_wr) && $stable(rb_wdata))); // R12
  AST_DONE_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_ns)
    (rb_req && rb_done) |=> !rb_req); // R5
  AST_LOAD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_ns)
    (rb_req && !rb_wr && rb_done) |=> (stg_val == $past(rb_rdata))); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !mgmt_re |=> $stable(mgmt_rdata)); // R13
  AST_FOREIGN_PHY_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (mgmt_re && !phy_hit) |=> (mgmt_rdata == '0)); // R11
endmodule

// File: tb/pseudo_phy_window_tb_top.sv
module pseudo_phy_window_tb_top;
  localparam logic [4:0] WPHY = 5'd30;
  localparam logic [4:0] XPHY = 5'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mgmt_phy = '0;
  logic [4:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic        mgmt_we = 1'b0;
  logic        mgmt_re = 1'b0;
  logic [15:0] mgmt_rdata;
  logic        rb_req, rb_wr;
  logic [7:0]  rb_page, rb_offset;
  logic [63:0] rb_wdata;
  logic [63:0] rb_rdata = '0;
  logic        rb_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int acc_cnt = 0;
  int n_acc = 0;
  logic        log_wr;
  logic [7:0]  log_page, log_ofs;
  logic [63:0] log_wdata;

  always #5 clk = ~clk;

  pseudo_phy_window dut_i (
    .clk(clk), .rst_n(rst_n),
    .mgmt_phy(mgmt_phy), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_we(mgmt_we), .mgmt_re(mgmt_re), .mgmt_rdata(mgmt_rdata),
    .rb_req(rb_req), .rb_wr(rb_wr), .rb_page(rb_page), .rb_offset(rb_offset),
    .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .rb_done(rb_done)
  );

  function automatic logic [63:0] pat(input logic [7:0] p, input logic [7:0] o);
    return {p, o, ~p, ~o, p ^ o, 8'h3C, 16'hBEEF};
  endfunction

  // internal register file model: completes each request after 'lat' cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      acc_cnt = 0;
      rb_done = 1'b0;
    end else if (rb_done) begin
      rb_done = 1'b0;
      acc_cnt = 0;
    end else if (rb_req) begin
      if (acc_cnt >= lat) begin
        rb_done   = 1'b1;
        rb_rdata  = pat(rb_page, rb_offset);
        log_wr    = rb_wr;
        log_page  = rb_page;
        log_ofs   = rb_offset;
        log_wdata = rb_wdata;
        n_acc++;
      end else begin
        acc_cnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mwrite(input logic [4:0] phy, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_phy = phy; mgmt_addr = a; mgmt_wdata = d; mgmt_we = 1'b1;
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  task automatic mread(input logic [4:0] phy, input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    mgmt_phy = phy; mgmt_addr = a; mgmt_re = 1'b1;
    @(negedge clk);
    mgmt_re = 1'b0;
    d = mgmt_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] s;
    int tries = 0;
    s = 16'h0003;
    while (s[1:0] != 2'b00 && tries < 100) begin
      mread(WPHY, 5'h11, s);
      tries++;
    end
    if (s[1:0] != 2'b00) chk(tag, {48'd0, s}, 64'd0);
  endtask

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  addr;
    logic [15:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t [0:NV-1] VECS = '{
    '{1'b0, WPHY, 5'h18, 16'h1111, 8'd10},
    '{1'b0, WPHY, 5'h19, 16'h2222, 8'd10},
    '{1'b0, WPHY, 5'h1A, 16'h3333, 8'd10},
    '{1'b0, WPHY, 5'h1B, 16'h4444, 8'd10},
    '{1'b1, WPHY, 5'h18, 16'h1111, 8'd10},
    '{1'b1, WPHY, 5'h1A, 16'h3333, 8'd10},
    '{1'b1, WPHY, 5'h1B, 16'h4444, 8'd10},
    '{1'b0, WPHY, 5'h10, 16'hAB01, 8'd2},
    '{1'b1, WPHY, 5'h10, 16'hAB00, 8'd2},
    '{1'b0, WPHY, 5'h10, 16'hCDFE, 8'd3},
    '{1'b1, WPHY, 5'h10, 16'hAB00, 8'd3},
    '{1'b0, XPHY, 5'h18, 16'h9999, 8'd11},
    '{1'b1, WPHY, 5'h18, 16'h1111, 8'd11},
    '{1'b1, XPHY, 5'h18, 16'h0000, 8'd11},
    '{1'b1, WPHY, 5'h05, 16'h0000, 8'd11},
    '{1'b1, WPHY, 5'h12, 16'h0000, 8'd11},
    '{1'b1, WPHY, 5'h11, 16'h0000, 8'd5}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    logic [63:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", {48'd0, mgmt_rdata}, 64'd0);
    chk("R1 rb_req", {63'd0, rb_req}, 64'd0);
    mread(WPHY, 5'h10, r); chk("R1 page", {48'd0, r}, 64'd0);
    mread(WPHY, 5'h11, r); chk("R1 cmd", {48'd0, r}, 64'd0);
    mread(WPHY, 5'h19, r); chk("R1 stage", {48'd0, r}, 64'd0);

    // vector table: R2 R3 R10 R11 register access
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        mread(VECS[i].phy, VECS[i].addr, r);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), {48'd0, r}, {48'd0, VECS[i].data});
      end else begin
        mwrite(VECS[i].phy, VECS[i].addr, VECS[i].data);
      end
    end

    // R13 read data holds without a read strobe
    mread(WPHY, 5'h19, r);
    mwrite(WPHY, 5'h19, 16'h2222);
    repeat (2) @(negedge clk);
    chk("R13 hold", {48'd0, mgmt_rdata}, 64'h2222);

    // R4 R8 internal write, long latency
    lat = 20;
    mwrite(WPHY, 5'h11, 16'h4201);
    chk("R4 req", {63'd0, rb_req}, 64'd1);
    chk("R4 wr", {63'd0, rb_wr}, 64'd1);
    chk("R4 page", {56'd0, rb_page}, 64'hAB);
    chk("R4 offset", {56'd0, rb_offset}, 64'h42);
    chk("R8 wdata", rb_wdata, 64'h4444_3333_2222_1111);
    mread(WPHY, 5'h11, r); chk("R5 write busy", {48'd0, r}, 64'h4201);
    // R7 R12 writes while busy are ignored
    mwrite(WPHY, 5'h18, 16'hFFFF);
    mwrite(WPHY, 5'h10, 16'h7701);
    mwrite(WPHY, 5'h11, 16'h5502);
    mread(WPHY, 5'h11, r); chk("R7 cmd while busy", {48'd0, r}, 64'h4201);
    chk("R12 page while busy", {56'd0, rb_page}, 64'hAB);
    wait_idle("R5 idle after write");
    chk("R8 logged wr", {63'd0, log_wr}, 64'd1);
    chk("R8 logged wdata", log_wdata, 64'h4444_3333_2222_1111);
    chk("R12 logged page", {56'd0, log_page}, 64'hAB);
    chk("R7 logged offset", {56'd0, log_ofs}, 64'h42);
    chk("R7 single access", n_acc, 1);
    mread(WPHY, 5'h18, r); chk("R12 stage kept", {48'd0, r}, 64'h1111);
    mread(WPHY, 5'h10, r); chk("R12 page kept", {48'd0, r}, 64'hAB00);
    mread(WPHY, 5'h11, r); chk("R5 cleared", {48'd0, r}, 64'h4200);

    // R9 R10 internal read, zero latency
    lat = 0;
    mwrite(WPHY, 5'h11, 16'h6602);
    wait_idle("R9 idle after read");
    chk("R9 logged rd", {63'd0, log_wr}, 64'd0);
    p = pat(8'hAB, 8'h66);
    for (int w = 0; w < 4; w++) begin
      mread(WPHY, 5'(5'h18 + w), r);
      chk($sformatf("R9 stage word %0d", w), {48'd0, r}, {48'd0, p[w*16 +: 16]});
    end

    // R6 both request bits means read
    lat = 10;
    mwrite(WPHY, 5'h10, 16'h3C01);
    mwrite(WPHY, 5'h11, 16'h7703);
    chk("R6 rb_wr low", {63'd0, rb_wr}, 64'd0);
    mread(WPHY, 5'h11, r); chk("R6 read busy only", {48'd0, r}, 64'h7702);
    wait_idle("R6 idle");
    mread(WPHY, 5'h1B, r); chk("R6 read result", {48'd0, r}, {48'd0, pat(8'h3C, 8'h77)} >> 48);

    // R4 command with no request bit starts nothing
    mwrite(WPHY, 5'h11, 16'h1200);
    chk("R4 no request", {63'd0, rb_req}, 64'd0);
    mread(WPHY, 5'h11, r); chk("R4 offset only", {48'd0, r}, 64'h1200);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule